// File: doc/BRIEF.md
# Interrupt Line Pending-Word Forwarder

The block watches a bank of interrupt input lines and condenses their activity into shared 16-bit words that a downstream interrupt controller drains: a set word that lists lines asking for service, a clear word that lists level lines that have dropped their request, and an edge-history word that filters edge lines so each rising edge is reported once. A per-line trigger-select bit, loaded through a small write port, picks level or edge behaviour. Whenever a line's activity changes one of the reported words, a one-cycle notify pulse tells the consumer that work is waiting.

The consumer half is part of the block. A drain request snapshots the clear word and the set word and zeroes both in the same clock edge, so no update can fall between the read and the zeroing. The snapshot is presented as a clear mask and a set mask on a valid/ready output. The controller applies the clear mask before the set mask. Bit i of every word belongs to input line i, so bits 7:0 serve the first eight-line controller and bits 15:8 the second.

Back-pressure rules: the snapshot appears with `out_valid` one cycle after the drain request is accepted, and it stays stable until a cycle in which `out_ready` is high. A drain request is accepted only when no snapshot is held, or when the held snapshot is handed over in that same cycle. A request that arrives while a snapshot is held and `out_ready` is low is ignored, and the words keep accumulating.

Top module: `irq_word_fwd`

## Requirements
- R1: After reset all words, the edge history, `notify` and `out_valid` are zero, and a first drain returns zero masks.
- R2: On a level line (trigger bit 1), a change of the input from 0 to 1 sets the line's set-word bit and clears its clear-word bit.
- R3: On a level line, a change of the input from 1 to 0 sets the line's clear-word bit and clears its set-word bit.
- R4: On an edge line (trigger bit 0), a change of the input from 0 to 1 while its history bit is 0 sets both its set-word bit and its history bit.
- R5: An edge line held high for many cycles reports one request only, and raises no further notify pulse.
- R6: An edge line falling clears only its history bit. Its set-word bit is left as it was, and no notify pulse follows.
- R7: `notify` is high for exactly the cycle after a clock edge on which a level line changed or an edge line produced a new rising edge, and is low otherwise.
- R8: An accepted drain captures the clear word and the set word as they stood before that edge, and zeroes both on the same edge. The captured values appear on `out_clr` and `out_set` with `out_valid` in the following cycle.
- R9: A line update that lands on the same edge as a drain is kept in the words and is returned by the next drain.
- R10: While `out_valid` is high and `out_ready` is low, the masks and valid hold, and a drain request is ignored.
- R11: Line i maps to bit i of every word and mask. Lines 0 to 7 land in bits 7:0, and lines 8 to 15 land in bits 15:8.
- R12: A write on the trigger-select port takes effect for input changes sampled from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines, sampled once per clock |
| trig_we | input | 1 | Load the trigger-select word |
| trig_wdata | input | 16 | New trigger-select word, 1 = level, 0 = edge |
| notify | output | 1 | One-cycle pulse: the words have new content |
| drain_req | input | 1 | Request to snapshot and zero the clear and set words |
| out_valid | output | 1 | Snapshot masks are valid |
| out_ready | input | 1 | Consumer takes the snapshot |
| out_clr | output | 16 | Clear mask, to be applied first |
| out_set | output | 16 | Set mask, to be applied after the clear mask |

## Verification
The bench targets the edge filter. It holds an edge line high for several cycles and then drops it. A design that fed level behaviour to edge lines would report the line again or raise a clear bit. A design that let the fall touch the set word would lose the pending request. It lands a rising edge on the same edge as a drain, where a design that zeroed the word after merging would lose the interrupt for good. It stalls the output and issues a drain meanwhile: a design that accepted that drain would overwrite the held masks or zero words nobody read. Finally it rewrites the trigger word on a live line and places activity on both byte halves to expose swapped or misrouted bit positions.

// File: rtl/irqfwd_pkg.sv
package irqfwd_pkg;
  localparam int unsigned IRQ_LINES = 16;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irqfwd_line.sv
module irqfwd_line
  import irqfwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic trig,
  input  logic take,
  output logic set_q,
  output logic clr_q,
  output logic note
);
  logic prev_q, hist_q;
  logic rise, fall;
  logic set_base, clr_base;
  logic set_d, clr_d, hist_d;

  assign rise = line_in & ~prev_q;
  assign fall = ~line_in & prev_q;

  // a drain zeroes the words first, then this cycle's update is merged in
  assign set_base = take ? 1'b0 : set_q;
  assign clr_base = take ? 1'b0 : clr_q;

  always_comb begin
    set_d  = set_base;
    clr_d  = clr_base;
    hist_d = hist_q;
    note   = 1'b0;
    if (trig_mode_e'(trig) == TRIG_LEVEL) begin
      if (rise) begin
        set_d = 1'b1;
        clr_d = 1'b0;
        note  = 1'b1;
      end else if (fall) begin
        set_d = 1'b0;
        clr_d = 1'b1;
        note  = 1'b1;
      end
    end else begin
      if (rise && !hist_q) begin
        set_d  = 1'b1;
        hist_d = 1'b1;
        note   = 1'b1;
      end else if (fall) begin
        hist_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      prev_q <= line_in;
      hist_q <= hist_d;
      set_q  <= set_d;
      clr_q  <= clr_d;
    end
  end

  AST_LVL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && rise) |=> (set_q && !clr_q)); // R2
  AST_LVL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && fall) |=> (clr_q && !set_q)); // R3
  AST_EDGE_FALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && fall && !take) |=> (set_q == $past(set_q))); // R6
  AST_DRAIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rise && !fall) |=> (!set_q && !clr_q)); // R8
endmodule

// File: rtl/irqfwd_drain.sv
module irqfwd_drain #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_word,
  input  logic [W-1:0] clr_word,
  input  logic         drain_req,
  input  logic         out_ready,
  output logic         take,
  output logic         out_valid,
  output logic [W-1:0] out_set,
  output logic [W-1:0] out_clr
);
  assign take = drain_req && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_set   <= '0;
      out_clr   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_set   <= set_word;
      out_clr   <= clr_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_set) && $stable(out_clr))); // R10
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !take); // R10
endmodule

// File: rtl/irq_word_fwd.sv
module irq_word_fwd
  import irqfwd_pkg::*;
#(
  parameter int unsigned NLINES = IRQ_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              trig_we,
  input  logic [NLINES-1:0] trig_wdata,
  output logic              notify,
  input  logic              drain_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NLINES-1:0] out_clr,
  output logic [NLINES-1:0] out_set
);
  logic [NLINES-1:0] trig_q;
  logic [NLINES-1:0] set_word, clr_word, notes;
  logic              take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= '0;
      notify <= 1'b0;
    end else begin
      if (trig_we) trig_q <= trig_wdata;
      notify <= |notes;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    irqfwd_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_in(irq_in[i]),
      .trig   (trig_q[i]),
      .take   (take),
      .set_q  (set_word[i]),
      .clr_q  (clr_word[i]),
      .note   (notes[i])
    );
  end

  irqfwd_drain #(.W(NLINES)) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_word (set_word),
    .clr_word (clr_word),
    .drain_req(drain_req),
    .out_ready(out_ready),
    .take     (take),
    .out_valid(out_valid),
    .out_set  (out_set),
    .out_clr  (out_clr)
  );

  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (notes == '0) |=> !notify); // R7
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R8
endmodule

// File: tb/irq_word_fwd_tb.sv
module irq_word_fwd_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic trig_we = 1'b0;
  logic [N-1:0] trig_wdata = '0;
  logic notify;
  logic drain_req = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N-1:0] out_clr, out_set;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [N-1:0] m_set = '0, m_clr = '0, m_hist = '0, m_prev = '0, m_trig = '0;
  logic m_valid = 1'b0;
  logic [2*N-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  irq_word_fwd u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_we(trig_we),
    .trig_wdata(trig_wdata), .notify(notify), .drain_req(drain_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_clr(out_clr), .out_set(out_set)
  );

  task automatic check(input bit ok, input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: drives one cycle, updates the model, pushes expected snapshots
  task automatic step(input logic [N-1:0] lines, input bit drain, input bit ready,
                      input bit twe, input logic [N-1:0] twd, input string req);
    bit take, exp_note;
    irq_in = lines; drain_req = drain; out_ready = ready;
    trig_we = twe; trig_wdata = twd;
    take = drain && (!m_valid || ready);
    if (take) begin
      exp_q.push_back({m_clr, m_set});
      tag_q.push_back(req);
      m_set = '0; m_clr = '0;
    end
    exp_note = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (m_trig[i]) begin
        if (lines[i] && !m_prev[i]) begin m_set[i] = 1'b1; m_clr[i] = 1'b0; exp_note = 1'b1; end
        else if (!lines[i] && m_prev[i]) begin m_clr[i] = 1'b1; m_set[i] = 1'b0; exp_note = 1'b1; end
      end else begin
        if (lines[i] && !m_prev[i] && !m_hist[i]) begin m_set[i] = 1'b1; m_hist[i] = 1'b1; exp_note = 1'b1; end
        else if (!lines[i] && m_prev[i]) m_hist[i] = 1'b0;
      end
    end
    m_prev = lines;
    if (twe) m_trig = twd;
    if (take) m_valid = 1'b1;
    else if (ready) m_valid = 1'b0;
    @(posedge clk);
    #1;
    check(notify === exp_note, {req, " R7 notify"}, {31'b0, notify}, {31'b0, exp_note});
    check(out_valid === m_valid, {req, " valid"}, {31'b0, out_valid}, {31'b0, m_valid});
    trig_we = 1'b0; drain_req = 1'b0;
  endtask

  // monitor: pops expected snapshots on each handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected snapshot", {out_clr, out_set}, '0);
      end else begin
        logic [2*N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_clr, out_set} === e, {t, " masks"}, {out_clr, out_set}, e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      check(1'b0, "watchdog", '0, '1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check(notify === 1'b0 && out_valid === 1'b0, "R1 reset outputs", {30'b0, notify, out_valid}, '0);
    step('0, 1, 1, 0, '0, "R1 first drain zero");
    step('0, 0, 1, 1, 16'h0F0F, "R12 trig write");          // line 3, 9 level; line 12 edge
    step(16'h0008, 0, 1, 0, '0, "R2 R11 level rise line3");
    step(16'h0008, 1, 1, 0, '0, "R2 R8 drain set bit3");
    step(16'h0000, 0, 1, 0, '0, "R3 level fall line3");
    step(16'h0000, 1, 1, 0, '0, "R3 drain clr bit3");
    step(16'h1000, 0, 1, 0, '0, "R4 R11 edge rise line12");
    for (int k = 0; k < 4; k++) step(16'h1000, 0, 1, 0, '0, "R5 edge held high");
    step(16'h1000, 1, 1, 0, '0, "R4 R5 drain one request");
    step(16'h1000, 1, 1, 0, '0, "R5 no repeat request");
    step(16'h0000, 0, 1, 0, '0, "R6 edge fall");
    step(16'h1000, 0, 1, 0, '0, "R6 re-rise line12");
    step(16'h0000, 0, 1, 0, '0, "R6 fall keeps set");
    step(16'h0000, 1, 1, 0, '0, "R6 drain set kept no clr");
    step(16'h1000, 1, 1, 0, '0, "R9 rise with drain");
    step(16'h1000, 1, 1, 0, '0, "R9 survivor drained");
    step(16'h1200, 0, 1, 0, '0, "R11 level rise line9");
    step(16'h1200, 1, 0, 0, '0, "R10 drain then stall");
    step(16'h1201, 1, 0, 0, '0, "R10 drain ignored while held");
    step(16'h1201, 0, 0, 0, '0, "R10 still held");
    step(16'h1201, 0, 1, 0, '0, "R10 released");
    step(16'h1201, 1, 1, 0, '0, "R10 later drain gets line0");
    step(16'h1201, 0, 1, 1, 16'h0F07, "R12 line3 to edge");
    step(16'h1209, 0, 1, 0, '0, "R12 edge rise line3");
    step(16'h1201, 0, 1, 0, '0, "R12 edge fall line3");
    step(16'h1201, 1, 1, 0, '0, "R12 drain set bit3 only");
    step(16'hF0FF, 0, 1, 0, '0, "R11 both halves toggle");
    step(16'h0F00, 1, 1, 0, '0, "R11 both halves drain");
    step(16'h0F00, 1, 1, 0, '0, "R8 drain after drain");
    step('0, 0, 1, 0, '0, "idle");
    step('0, 0, 1, 0, '0, "idle");
    check(exp_q.size() == 0, "R8 all snapshots seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule